// File: doc/BRIEF.md
# Secure-Element Command Frame Checker

This block sits behind a byte-level serial slave front end and judges each command frame sent to a secure element. The front end marks each frame with a start strobe, hands over its bytes one per cycle with a valid flag, and closes it with a stop strobe. The checker stores the frame and runs a CRC-16 over it as the bytes arrive. When the frame closes, it decides whether the frame may go to a command handler. Each frame gets exactly one one-byte status.

An accepted frame goes out on the dispatch port. The command ID is held steady and the payload bytes are streamed one per cycle, with first and last markers. The OK status follows. A rejected frame produces no dispatch, only its error status. The checks run in a fixed order: overflow, then short frame, then CRC, then the locked command, then the supported set, then the arguments.

The controller is a five-state machine:
- IDLE waits for a start strobe.
- RECV collects bytes. A start strobe restarts the frame. A stop strobe leads to CHECK.
- CHECK spends one cycle forming the verdict. It goes to SEND when an accepted frame has payload, and to STATUS otherwise.
- SEND streams the payload and moves to STATUS after the last byte.
- STATUS emits the status pulse and returns to IDLE.

Top module: `se_frame_check`

## Requirements
- R1: A frame of n bytes carries the command ID in byte 0 and a CRC in bytes n-2 (low byte) and n-1 (high byte). The CRC covers bytes 0 to n-3 and uses the reflected polynomial 0x8408 with start value 0xFFFF, and the final register value is inverted.
- R2: A frame that passes all checks streams bytes 1 to n-3 in order on `dsp_data`, one per cycle, with `dsp_valid` high. `dsp_first` marks the first of these bytes and `dsp_last` the last, and `dsp_cmd` holds byte 0. The cycle after the last byte, status 0x00 is reported.
- R3: A CRC mismatch reports status 0x01 and dispatches nothing. This takes priority over every command decode, including 0x13 and unsupported IDs.
- R4: A command ID outside the set 0x00, 0x02, 0x05, 0x06, 0x0D, 0x11, 0x14, 0x16, 0x17, 0x18 (and other than 0x13) reports status 0x04 and dispatches nothing.
- R5: Command 0x13 with a correct CRC always reports status 0x0F and dispatches nothing.
- R6: Command 0x18 is accepted only if the frame is exactly 0x49 bytes and byte 1 equals 0xFF. Otherwise it reports status 0x02 with no dispatch.
- R7: A frame with more than BUF_DEPTH bytes reports status 0x06 and dispatches nothing, whatever its content. The extra bytes are dropped.
- R8: A frame shorter than 3 bytes reports status 0x02 with no dispatch.
- R9: Bytes count only between a start strobe and a stop strobe. Bytes seen before a start do not enter the next frame, and a second start within a frame discards the bytes collected so far.
- R10: Each frame yields exactly one `sts_valid` pulse, one cycle long, never in the same cycle as `dsp_valid`. The status code is one of 0x00, 0x01, 0x02, 0x04, 0x06, 0x0F, and `sts_code` is 0 whenever `sts_valid` is low.
- R11: An accepted 3-byte frame, which has no payload, reports status 0x00 without any `dsp_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_start | input | 1 | Frame start strobe |
| rx_valid | input | 1 | Byte valid |
| rx_data | input | 8 | Received byte |
| rx_stop | input | 1 | Frame end strobe |
| dsp_valid | output | 1 | Payload byte valid on dispatch port |
| dsp_first | output | 1 | First payload byte |
| dsp_last | output | 1 | Last payload byte |
| dsp_cmd | output | 8 | Command ID of dispatched frame |
| dsp_data | output | 8 | Payload byte |
| sts_valid | output | 1 | Status pulse |
| sts_code | output | 8 | Status code |

## Verification
Frames are built around each verdict:
- Correctly sealed frames of supported commands, with long, one-byte and empty payloads, check payload order and the first and last markers.
- Frames that are identical apart from a flipped CRC byte show that the CRC check ranks above the decode of unsupported and locked IDs.
- Frames of the fixed-length exchange command that are off by one byte, or that carry a wrong constant, separate an argument error from acceptance.
- An over-long frame with a valid CRC, a two-byte frame, and junk bytes sent before a start or before a restart show that the length checks and the frame boundaries act independently of the CRC result.

// File: rtl/se_frame_pkg.sv
package se_frame_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_CHECK,
        ST_SEND,
        ST_STATUS
    } fc_state_t;

    localparam logic [7:0] STS_OK       = 8'h00;
    localparam logic [7:0] STS_BAD_CRC  = 8'h01;
    localparam logic [7:0] STS_BAD_ARG  = 8'h02;
    localparam logic [7:0] STS_UNSUP    = 8'h04;
    localparam logic [7:0] STS_TOO_LONG = 8'h06;
    localparam logic [7:0] STS_LOCKED   = 8'h0F;

    localparam logic [7:0] CMD_LOCKED   = 8'h13;
    localparam logic [7:0] CMD_XCHG     = 8'h18;
    localparam logic [7:0] XCHG_CONST   = 8'hFF;
    localparam int         XCHG_LEN     = 73;
    localparam int         MIN_LEN      = 3;

    localparam logic [15:0] CRC_POLY_R  = 16'h8408;
    localparam logic [15:0] CRC_SEED    = 16'hFFFF;

    // one reflected CRC-16 byte update, LSB first
    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/se_crc16.sv
module se_crc16
    import se_frame_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [15:0] crc_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      crc_q <= CRC_SEED;
        else if (clear)  crc_q <= CRC_SEED;
        else if (en)     crc_q <= crc_byte(crc_q, data);
    end
endmodule

// File: rtl/se_frame_buf.sv
module se_frame_buf #(
    parameter int DEPTH = 80,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
    end

    always_comb begin
        rd_data = 8'h00;
        if (int'(rd_addr) < DEPTH) rd_data = mem[rd_addr];
    end
endmodule

// File: rtl/se_cmd_decode.sv
module se_cmd_decode
    import se_frame_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic [7:0]    cmd_id,
    input  logic [7:0]    arg0,
    input  logic [AW-1:0] frame_len,
    output logic          supported,
    output logic          locked,
    output logic          args_ok
);
    always_comb begin
        case (cmd_id)
            8'h00, 8'h02, 8'h05, 8'h06, 8'h0D,
            8'h11, 8'h14, 8'h16, 8'h17, 8'h18: supported = 1'b1;
            default:                           supported = 1'b0;
        endcase
        locked  = (cmd_id == CMD_LOCKED);
        args_ok = (cmd_id != CMD_XCHG) ||
                  ((int'(frame_len) == XCHG_LEN) && (arg0 == XCHG_CONST));
    end
endmodule

// File: rtl/se_frame_check.sv
module se_frame_check
    import se_frame_pkg::*;
#(
    parameter int BUF_DEPTH = 80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_start,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_stop,
    output logic       dsp_valid,
    output logic       dsp_first,
    output logic       dsp_last,
    output logic [7:0] dsp_cmd,
    output logic [7:0] dsp_data,
    output logic       sts_valid,
    output logic [7:0] sts_code
);
    localparam int AW = $clog2(BUF_DEPTH + 1);

    fc_state_t     state, state_nx;
    logic [AW-1:0] rx_cnt, send_idx, last_idx;
    logic          ovf;
    logic [7:0]    cmd_q, arg0_q, tail1, tail2, verdict_q, verdict_c;
    logic [15:0]   crc_q;
    logic          taking, restart, byte_in, crc_ok;
    logic          supported, locked, args_ok;
    logic [7:0]    rd_data;

    assign taking  = (state == ST_IDLE) || (state == ST_RECV);
    assign restart = taking && rx_start;
    assign byte_in = (state == ST_RECV) && !rx_start && rx_valid;
    assign crc_ok  = ({tail1, tail2} == ~crc_q);
    assign last_idx = rx_cnt - AW'(MIN_LEN);

    se_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .en    (byte_in && (rx_cnt >= AW'(2))),
        .data  (tail2),
        .crc_q (crc_q)
    );

    se_frame_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
        .clk     (clk),
        .wr_en   (byte_in && (rx_cnt != AW'(BUF_DEPTH))),
        .wr_addr (rx_cnt),
        .wr_data (rx_data),
        .rd_addr (send_idx),
        .rd_data (rd_data)
    );

    se_cmd_decode #(.AW(AW)) u_dec (
        .cmd_id    (cmd_q),
        .arg0      (arg0_q),
        .frame_len (rx_cnt),
        .supported (supported),
        .locked    (locked),
        .args_ok   (args_ok)
    );

    // verdict in priority order
    always_comb begin
        if (ovf)                         verdict_c = STS_TOO_LONG;
        else if (rx_cnt < AW'(MIN_LEN))  verdict_c = STS_BAD_ARG;
        else if (!crc_ok)                verdict_c = STS_BAD_CRC;
        else if (locked)                 verdict_c = STS_LOCKED;
        else if (!supported)             verdict_c = STS_UNSUP;
        else if (!args_ok)               verdict_c = STS_BAD_ARG;
        else                             verdict_c = STS_OK;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (rx_start) state_nx = ST_RECV;
            ST_RECV:   if (rx_start)     state_nx = ST_RECV;
                       else if (rx_stop) state_nx = ST_CHECK;
            ST_CHECK:  if ((verdict_c == STS_OK) && (rx_cnt > AW'(MIN_LEN)))
                           state_nx = ST_SEND;
                       else
                           state_nx = ST_STATUS;
            ST_SEND:   if (send_idx == last_idx) state_nx = ST_STATUS;
            ST_STATUS: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_cnt    <= '0;
            ovf       <= 1'b0;
            cmd_q     <= 8'h00;
            arg0_q    <= 8'h00;
            tail1     <= 8'h00;
            tail2     <= 8'h00;
            verdict_q <= 8'h00;
            send_idx  <= '0;
        end else begin
            if (restart) begin
                rx_cnt <= '0;
                ovf    <= 1'b0;
            end else if (byte_in) begin
                tail1 <= rx_data;
                tail2 <= tail1;
                if (rx_cnt == AW'(BUF_DEPTH)) begin
                    ovf <= 1'b1;
                end else begin
                    rx_cnt <= rx_cnt + AW'(1);
                    if (rx_cnt == AW'(0)) cmd_q  <= rx_data;
                    if (rx_cnt == AW'(1)) arg0_q <= rx_data;
                end
            end
            if (state == ST_CHECK) begin
                verdict_q <= verdict_c;
                send_idx  <= AW'(1);
            end else if (state == ST_SEND) begin
                send_idx  <= send_idx + AW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        dsp_valid = (state == ST_SEND);
        dsp_first = (state == ST_SEND) && (send_idx == AW'(1));
        dsp_last  = (state == ST_SEND) && (send_idx == last_idx);
        dsp_cmd   = cmd_q;
        dsp_data  = (state == ST_SEND) ? rd_data : 8'h00;
        sts_valid = (state == ST_STATUS);
        sts_code  = (state == ST_STATUS) ? verdict_q : 8'h00;
    end
endmodule

// File: rtl/se_frame_check_sva.sv
module se_frame_check_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       dsp_valid,
    input logic       dsp_first,
    input logic       dsp_last,
    input logic       sts_valid,
    input logic [7:0] sts_code
);
    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dsp_valid && sts_valid));

    // R10
    sts_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |=> !sts_valid);

    // R10
    sts_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |-> (sts_code inside {8'h00, 8'h01, 8'h02, 8'h04, 8'h06, 8'h0F}));

    // R10
    sts_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_valid |-> (sts_code == 8'h00));

    // R2
    ok_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_last |=> (sts_valid && (sts_code == 8'h00)));

    // R2
    burst_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && !dsp_last) |=> (dsp_valid && !dsp_first));

    // R2
    burst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dsp_valid) |-> dsp_first);
endmodule

bind se_frame_check se_frame_check_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .dsp_valid (dsp_valid),
    .dsp_first (dsp_first),
    .dsp_last  (dsp_last),
    .sts_valid (sts_valid),
    .sts_code  (sts_code)
);

// File: tb/se_frame_check_tb.sv
module se_frame_check_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_start = 1'b0, rx_valid = 1'b0, rx_stop = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       dsp_valid, dsp_first, dsp_last, sts_valid;
    logic [7:0] dsp_cmd, dsp_data, sts_code;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [7:0] fr  [0:127];
    logic [7:0] got [0:127];
    int         got_n;
    logic [7:0] got_sts;
    logic [7:0] got_cmd;
    bit         marks_ok;
    bit         saw_sts;

    always #5 clk = ~clk;

    se_frame_check u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data), .rx_stop(rx_stop),
        .dsp_valid(dsp_valid), .dsp_first(dsp_first), .dsp_last(dsp_last),
        .dsp_cmd(dsp_cmd), .dsp_data(dsp_data),
        .sts_valid(sts_valid), .sts_code(sts_code)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] ref_crc(input int len);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {8'h00, fr[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // fill body bytes 1..n-3 with a pattern
    task automatic fill(input logic [7:0] id, input int n);
        fr[0] = id;
        for (int i = 1; i < n - 2; i++) fr[i] = 8'(i * 13 + 5);
    endtask

    // R1: CRC over bytes 0..n-3, low byte then high byte
    task automatic seal(input int n, input bit bad);
        logic [15:0] c = ref_crc(n - 2);
        fr[n-2] = c[7:0] ^ (bad ? 8'h40 : 8'h00);
        fr[n-1] = c[15:8];
    endtask

    task automatic send_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = fr[i];
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
    endtask

    task automatic finish_and_collect();
        @(negedge clk); rx_stop = 1'b1;
        @(negedge clk); rx_stop = 1'b0;
        got_n = 0; got_sts = 8'hEE; saw_sts = 0; marks_ok = 1;
        for (int k = 0; k < 200 && !saw_sts; k++) begin
            @(negedge clk);
            if (dsp_valid) begin
                if (dsp_first != (got_n == 0)) marks_ok = 0;
                got[got_n] = dsp_data; got_cmd = dsp_cmd; got_n++;
                if (dsp_last) marks_ok = marks_ok;
            end
            if (sts_valid) begin
                saw_sts = 1; got_sts = sts_code;
            end
        end
        @(negedge clk);
        if (sts_valid) saw_sts = 0;   // a second pulse breaks R10
    endtask

    task automatic run(input string req, input int n, input logic [7:0] exp_sts, input bit exp_dsp);
        int pay = exp_dsp ? n - 3 : 0;
        pulse_start();
        send_bytes(n);
        finish_and_collect();
        check({req, " status"}, got_sts, exp_sts);
        check({req, " R10 single pulse"}, saw_sts, 1);
        check({req, " dispatch count"}, got_n, pay);
        if (pay > 0) begin
            int bad = 0;
            for (int i = 0; i < pay; i++) if (got[i] !== fr[i+1]) bad++;
            check({req, " R2 payload bytes"}, bad, 0);
            check({req, " R2 cmd"}, got_cmd, fr[0]);
            check({req, " R2 first mark"}, marks_ok, 1);
        end
    endtask

    task automatic t_reset();
        check("R10 reset sts_valid", sts_valid, 0);
        check("R10 reset dsp_valid", dsp_valid, 0);
        check("R10 reset sts_code", sts_code, 0);
    endtask

    task automatic t_good();
        fill(8'h00, 8);  seal(8, 0);  run("R2 echo", 8, 8'h00, 1);
        fill(8'h05, 9);  seal(9, 0);  run("R1 read", 9, 8'h00, 1);
        fill(8'h16, 4);  seal(4, 0);  run("R2 one-byte", 4, 8'h00, 1);
        fill(8'h02, 3);  seal(3, 0);  run("R11 empty", 3, 8'h00, 0);
    endtask

    task automatic t_all_ids();
        logic [7:0] ids [10] = '{8'h00, 8'h02, 8'h05, 8'h06, 8'h0D, 8'h11, 8'h14, 8'h16, 8'h17, 8'h18};
        for (int j = 0; j < 9; j++) begin
            fill(ids[j], 6); seal(6, 0); run("R4 supported", 6, 8'h00, 1);
        end
    endtask

    task automatic t_crc();
        fill(8'h14, 7);  seal(7, 1);  run("R3 bad crc", 7, 8'h01, 0);
        fill(8'h13, 7);  seal(7, 1);  run("R3 bad crc over locked", 7, 8'h01, 0);
        fill(8'h07, 7);  seal(7, 1);  run("R3 bad crc over unsupported", 7, 8'h01, 0);
    endtask

    task automatic t_decode();
        fill(8'h07, 6);  seal(6, 0);  run("R4 unsupported 07", 6, 8'h04, 0);
        fill(8'hFF, 6);  seal(6, 0);  run("R4 unsupported FF", 6, 8'h04, 0);
        fill(8'h13, 6);  seal(6, 0);  run("R5 locked", 6, 8'h0F, 0);
    endtask

    task automatic t_xchg();
        fill(8'h18, 73); fr[1] = 8'hFF; seal(73, 0); run("R6 exchange ok", 73, 8'h00, 1);
        fill(8'h18, 72); fr[1] = 8'hFF; seal(72, 0); run("R6 exchange short", 72, 8'h02, 0);
        fill(8'h18, 74); fr[1] = 8'hFF; seal(74, 0); run("R6 exchange long", 74, 8'h02, 0);
        fill(8'h18, 73); fr[1] = 8'hFE; seal(73, 0); run("R6 exchange const", 73, 8'h02, 0);
    endtask

    task automatic t_len();
        fill(8'h00, 90); seal(90, 0); run("R7 overflow", 90, 8'h06, 0);
        fill(8'h00, 81); seal(81, 0); run("R7 overflow by one", 81, 8'h06, 0);
        fill(8'h00, 80); seal(80, 0); run("R7 full buffer", 80, 8'h00, 1);
        fr[0] = 8'h00; fr[1] = 8'h11; run("R8 two bytes", 2, 8'h02, 0);
    endtask

    task automatic t_bounds();
        // R9: junk before start, then a clean frame
        for (int i = 0; i < 4; i++) fr[i] = 8'h99;
        send_bytes(4);
        fill(8'h11, 7); seal(7, 0); run("R9 junk before start", 7, 8'h00, 1);
        // R9: restart in mid-frame
        pulse_start();
        for (int i = 0; i < 5; i++) fr[i] = 8'h5A;
        send_bytes(5);
        fill(8'h17, 6); seal(6, 0); run("R9 restart", 6, 8'h00, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good();
        t_all_ids();
        t_crc();
        t_decode();
        t_xchg();
        t_len();
        t_bounds();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule